// File: doc/BRIEF.md
# Deferred-Write Colour Palette Stage

This stage sits between a framebuffer fetch unit and the video output in a pixel pipeline. Once per four-pixel group it takes in one 16-bit framebuffer word and splits it into four 4-bit colour indices, presenting one index per pixel clock with the top nibble first. Each index selects one of 16 palette entries. An entry is a 16-bit RGBI value with red in bits 15:12, green in 11:8, blue in 7:4 and intensity in 3:0. The framebuffer is therefore read once every four clocks, while the palette is read on every clock.

The CPU can write palette entries through a single-cycle write port at any time. The palette RAM itself is never written while pixels are in flight. Instead, each write goes into a four-entry queue. That queue drains into the RAM at one entry per clock, and only once the visible part of the scanline has left the pipeline. During active display, a full queue raises a busy flag. Outside active display the queue drains as fast as the CPU can fill it, so the CPU can write without limit.

Both the pixel output and the two sync signals leave the stage two clocks after the edge that captures the word load. The colour output is forced to zero for every pixel slot whose display enable was low.

Top module: `palette_stage`

## Requirements
- R1: After reset, `pixelRgbi`, `hsyncOut`, `vsyncOut` and `cpuBusy` are 0 and all 16 palette entries hold 0.
- R2: For a word accepted with `wordLoad` high at clock edge t, pixel k (k = 0..3) shows the palette entry indexed by bits [15-4k:12-4k]. It appears on `pixelRgbi` after edge t+2+k, so the most significant nibble is shown first.
- R3: A visible pixel equals the stored 16-bit palette entry unchanged (R in [15:12], G in [11:8], B in [7:4], I in [3:0]), and every one of the 16 indices reaches its own entry.
- R4: A pixel slot whose `displayEnable` was low when captured produces `pixelRgbi` = 0.
- R5: `hsyncOut` and `vsyncOut` repeat `hsyncIn` and `vsyncIn` with the same delay as the pixels, appearing after edge t+2 for a value captured at edge t.
- R6: A palette write accepted while the display is active does not change any pixel shown during that active period.
- R7: The write queue holds 4 writes. `cpuBusy` is 1 exactly when 4 writes are pending, and a write presented while `cpuBusy` is 1 is discarded.
- R8: Pending writes drain one per clock, in order, starting with the second clock of blanking. A later write to the same entry wins, and `cpuBusy` drops after the second blank clock.
- R9: During blanking, a write on every clock to all 16 entries is accepted without `cpuBusy` rising, and every write takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Active-low synchronous reset |
| displayEnable | input | 1 | High while the current pixel slot is visible |
| wordLoad | input | 1 | Strobe marking the first pixel of a four-pixel group |
| fbWord | input | 16 | Framebuffer word holding four 4-bit indices |
| hsyncIn | input | 1 | Horizontal sync aligned with the current slot |
| vsyncIn | input | 1 | Vertical sync aligned with the current slot |
| cpuWrEn | input | 1 | CPU palette write request |
| cpuWrAddr | input | 4 | Palette entry to write |
| cpuWrData | input | 16 | RGBI value to store |
| cpuBusy | output | 1 | Write queue full; the CPU must hold off |
| pixelRgbi | output | 16 | Colour for the current pixel |
| hsyncOut | output | 1 | Delayed horizontal sync |
| vsyncOut | output | 1 | Delayed vertical sync |

## Verification
The bench builds the stage with its default parameters: 4-bit indices, four pixels per word, 4-bit channels and a 4-deep queue. This keeps the palette at 16 entries, so every entry is written and shown, and a single arithmetic sweep of words puts each index value into every nibble position. The shallow queue can be filled within four clocks of one active line, which brings the busy flag, the discarded fifth write and the exact drain-start cycle within reach. The bench compares every output slot against a model of the pipeline timing built from the requirements.

// File: rtl/palette_pkg.sv
`timescale 1ns/1ps
package palette_pkg;
  // Strobes issued by the write controller to the datapath each clock
  typedef struct packed {
    logic push;   // store the CPU write in the queue slot at wrPtr
    logic pop;    // move the queue slot at rdPtr into the palette RAM
  } fifo_strobe_t;
endpackage

// File: rtl/palette_wr_ctrl.sv
`timescale 1ns/1ps
module palette_wr_ctrl
  import palette_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             displayEnable,
  input  logic             pipeIdle,
  input  logic             cpuWrEn,
  output fifo_strobe_t     strobe,
  output logic [PTR_W-1:0] wrPtr,
  output logic [PTR_W-1:0] rdPtr,
  output logic             busy
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

  logic [CNT_W-1:0] count;
  logic             full;
  logic             empty;

  function automatic logic [PTR_W-1:0] advance(input logic [PTR_W-1:0] p);
    return (p == LAST_PTR) ? '0 : p + 1'b1;
  endfunction

  assign full  = (count == FULL_CNT);
  assign empty = (count == '0);
  assign busy  = full;

  always_comb begin
    strobe.push = cpuWrEn && !full;
    // drain only when neither the current slot nor the one in flight is visible
    strobe.pop  = !empty && !displayEnable && pipeIdle;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count <= '0;
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (strobe.push) wrPtr <= advance(wrPtr);
      if (strobe.pop)  rdPtr <= advance(rdPtr);
      case ({strobe.push, strobe.pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R7: a write offered to a full queue leaves it full and untouched
  assert_no_overflow_R7 : assert property (@(posedge clk) disable iff (!rstN)
    busy && cpuWrEn && !strobe.pop |=> busy && $stable(wrPtr));

  // R7: occupancy never passes the queue depth
  assert_count_bound_R7 : assert property (@(posedge clk) disable iff (!rstN)
    count <= FULL_CNT);

  // R8: with a clear pipeline and no new write, one entry leaves per clock
  assert_drain_rate_R8 : assert property (@(posedge clk) disable iff (!rstN)
    !empty && !displayEnable && pipeIdle && !cpuWrEn |=> count == $past(count) - 1'b1);
endmodule

// File: rtl/palette_datapath.sv
`timescale 1ns/1ps
module palette_datapath
  import palette_pkg::*;
#(
  parameter int IDX_W        = 4,
  parameter int PIX_PER_WORD = 4,
  parameter int COLOR_W      = 16,
  parameter int DEPTH        = 4,
  localparam int PTR_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int WORD_W  = IDX_W * PIX_PER_WORD,
  localparam int ENTRIES = 1 << IDX_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               displayEnable,
  input  logic               wordLoad,
  input  logic [WORD_W-1:0]  fbWord,
  input  logic               hsyncIn,
  input  logic               vsyncIn,
  input  logic [IDX_W-1:0]   cpuWrAddr,
  input  logic [COLOR_W-1:0] cpuWrData,
  input  fifo_strobe_t       strobe,
  input  logic [PTR_W-1:0]   wrPtr,
  input  logic [PTR_W-1:0]   rdPtr,
  output logic               pipeIdle,
  output logic [COLOR_W-1:0] pixelRgbi,
  output logic               hsyncOut,
  output logic               vsyncOut
);
  // sideband bit positions inside each pipeline stage
  localparam int SB_DE = 2;
  localparam int SB_HS = 1;
  localparam int SB_VS = 0;
  localparam int STAGES = 2;

  logic [WORD_W-1:0]  shiftReg;
  logic [IDX_W-1:0]   indexReg;
  logic [2:0]         side [STAGES];
  logic [COLOR_W-1:0] palMem   [ENTRIES];
  logic [IDX_W-1:0]   fifoAddr [DEPTH];
  logic [COLOR_W-1:0] fifoData [DEPTH];

  // pixel serializer: load on group start, otherwise move to the next nibble
  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
      indexReg <= '0;
    end else begin
      shiftReg <= wordLoad ? fbWord : (shiftReg << IDX_W);
      indexReg <= shiftReg[WORD_W-1 -: IDX_W];
    end
  end

  // display enable and sync travel beside the index
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < STAGES; s++) side[s] <= '0;
    end else begin
      side[0] <= {displayEnable, hsyncIn, vsyncIn};
      for (int s = 1; s < STAGES; s++) side[s] <= side[s-1];
    end
  end

  assign pipeIdle = !side[0][SB_DE];

  // write queue storage
  always_ff @(posedge clk) begin
    if (strobe.push) begin
      fifoAddr[wrPtr] <= cpuWrAddr;
      fifoData[wrPtr] <= cpuWrData;
    end
  end

  // palette RAM: one read port for pixels, one deferred write port
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int e = 0; e < ENTRIES; e++) palMem[e] <= '0;
    end else if (strobe.pop) begin
      palMem[fifoAddr[rdPtr]] <= fifoData[rdPtr];
    end
  end

  // output register with blank gating
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pixelRgbi <= '0;
      hsyncOut  <= 1'b0;
      vsyncOut  <= 1'b0;
    end else begin
      pixelRgbi <= side[STAGES-1][SB_DE] ? palMem[indexReg] : '0;
      hsyncOut  <= side[STAGES-1][SB_HS];
      vsyncOut  <= side[STAGES-1][SB_VS];
    end
  end

  // edges seen since reset, saturating; lets history-based checks start safely
  logic [1:0] warm;
  always_ff @(posedge clk) begin
    if (!rstN)              warm <= '0;
    else if (warm != 2'd3)  warm <= warm + 1'b1;
  end

  // R4: a slot captured while blank comes out black
  assert_blank_black_R4 : assert property (@(posedge clk) disable iff (!rstN)
    (warm == 2'd3) && !$past(displayEnable, 3) |-> pixelRgbi == '0);

  // R5: sync outputs follow inputs by the pixel latency
  assert_sync_delay_R5 : assert property (@(posedge clk) disable iff (!rstN)
    (warm == 2'd3) |-> (hsyncOut == $past(hsyncIn, 3)) && (vsyncOut == $past(vsyncIn, 3)));

  // R6: the palette RAM is only written while the display is blank
  assert_write_in_blank_R6 : assert property (@(posedge clk) disable iff (!rstN)
    strobe.pop |-> !displayEnable);
endmodule

// File: rtl/palette_stage.sv
`timescale 1ns/1ps
module palette_stage
  import palette_pkg::*;
#(
  parameter int IDX_W        = 4,
  parameter int PIX_PER_WORD = 4,
  parameter int CHAN_W       = 4,
  parameter int FIFO_DEPTH   = 4,
  localparam int WORD_W  = IDX_W * PIX_PER_WORD,
  localparam int COLOR_W = 4 * CHAN_W,
  localparam int PTR_W   = (FIFO_DEPTH > 1) ? $clog2(FIFO_DEPTH) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               displayEnable,
  input  logic               wordLoad,
  input  logic [WORD_W-1:0]  fbWord,
  input  logic               hsyncIn,
  input  logic               vsyncIn,
  input  logic               cpuWrEn,
  input  logic [IDX_W-1:0]   cpuWrAddr,
  input  logic [COLOR_W-1:0] cpuWrData,
  output logic               cpuBusy,
  output logic [COLOR_W-1:0] pixelRgbi,
  output logic               hsyncOut,
  output logic               vsyncOut
);
  fifo_strobe_t     strobe;
  logic [PTR_W-1:0] wrPtr;
  logic [PTR_W-1:0] rdPtr;
  logic             pipeIdle;

  palette_wr_ctrl #(.DEPTH(FIFO_DEPTH)) ctrl_i (
    .clk(clk), .rstN(rstN), .displayEnable(displayEnable), .pipeIdle(pipeIdle),
    .cpuWrEn(cpuWrEn), .strobe(strobe), .wrPtr(wrPtr), .rdPtr(rdPtr), .busy(cpuBusy)
  );

  palette_datapath #(
    .IDX_W(IDX_W), .PIX_PER_WORD(PIX_PER_WORD), .COLOR_W(COLOR_W), .DEPTH(FIFO_DEPTH)
  ) dp_i (
    .clk(clk), .rstN(rstN), .displayEnable(displayEnable), .wordLoad(wordLoad),
    .fbWord(fbWord), .hsyncIn(hsyncIn), .vsyncIn(vsyncIn), .cpuWrAddr(cpuWrAddr),
    .cpuWrData(cpuWrData), .strobe(strobe), .wrPtr(wrPtr), .rdPtr(rdPtr),
    .pipeIdle(pipeIdle), .pixelRgbi(pixelRgbi), .hsyncOut(hsyncOut), .vsyncOut(vsyncOut)
  );
endmodule

// File: tb/palette_stage_tb.sv
`timescale 1ns/1ps
module palette_stage_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        displayEnable = 1'b0;
  logic        wordLoad = 1'b0;
  logic [15:0] fbWord = '0;
  logic        hsyncIn = 1'b0;
  logic        vsyncIn = 1'b0;
  logic        cpuWrEn = 1'b0;
  logic [3:0]  cpuWrAddr = '0;
  logic [15:0] cpuWrData = '0;
  logic        cpuBusy;
  logic [15:0] pixelRgbi;
  logic        hsyncOut;
  logic        vsyncOut;

  always #10 clk = ~clk;   // 50 MHz

  palette_stage dut_i (
    .clk(clk), .rstN(rstN), .displayEnable(displayEnable), .wordLoad(wordLoad),
    .fbWord(fbWord), .hsyncIn(hsyncIn), .vsyncIn(vsyncIn), .cpuWrEn(cpuWrEn),
    .cpuWrAddr(cpuWrAddr), .cpuWrData(cpuWrData), .cpuBusy(cpuBusy),
    .pixelRgbi(pixelRgbi), .hsyncOut(hsyncOut), .vsyncOut(vsyncOut)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [15:0] model [16];
  logic [15:0] curWord = '0;
  int          cyc = 0;
  logic [15:0] expPix [4];
  logic        expHs  [4];
  logic        expVs  [4];
  string       expTag [4];
  string       curReq = "R2";

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // one pixel slot: check the slot three ticks back, drive this one, model it
  task automatic tick(input logic de, input logic ld, input logic [15:0] w,
                      input logic we, input logic [3:0] a, input logic [15:0] d);
    logic [3:0] idx;
    int s;
    if (cyc >= 3) begin
      s = (cyc - 3) % 4;
      chk(expTag[s], {16'h0, pixelRgbi}, {16'h0, expPix[s]});
      chk("R5", {31'h0, hsyncOut}, {31'h0, expHs[s]});
      chk("R5", {31'h0, vsyncOut}, {31'h0, expVs[s]});
    end
    displayEnable = de;
    wordLoad      = ld;
    fbWord        = w;
    hsyncIn       = cyc[2];
    vsyncIn       = cyc[4] ^ cyc[0];
    cpuWrEn       = we;
    cpuWrAddr     = a;
    cpuWrData     = d;
    if (ld) curWord = w;
    idx = curWord[15:12];
    curWord = curWord << 4;
    s = cyc % 4;
    expPix[s] = de ? model[idx] : 16'h0;
    expHs[s]  = hsyncIn;
    expVs[s]  = vsyncIn;
    expTag[s] = de ? curReq : "R4";
    cyc++;
    @(negedge clk);
  endtask

  task automatic blank(input int n);
    for (int i = 0; i < n; i++) tick(1'b0, 1'b0, 16'h0, 1'b0, 4'h0, 16'h0);
  endtask

  task automatic showWord(input logic [15:0] w);
    for (int p = 0; p < 4; p++) tick(1'b1, p == 0, w, 1'b0, 4'h0, 16'h0);
  endtask

  function automatic logic [15:0] entryVal(input int i);
    return 16'(i * 16'h1111) ^ 16'hA5C3;
  endfunction

  initial begin
    for (int e = 0; e < 16; e++) model[e] = 16'h0;
    repeat (3) @(negedge clk);
    // R1: reset state at the ports
    chk("R1", {16'h0, pixelRgbi}, 32'h0);
    chk("R1", {31'h0, hsyncOut}, 32'h0);
    chk("R1", {31'h0, vsyncOut}, 32'h0);
    chk("R1", {31'h0, cpuBusy}, 32'h0);
    rstN = 1'b1;

    // R1: palette starts cleared, every index shows black
    blank(4);
    curReq = "R1";
    showWord(16'h0123); showWord(16'h4567); showWord(16'h89AB); showWord(16'hCDEF);
    blank(4);

    // R9: back-to-back writes during blanking, all 16 entries
    for (int i = 0; i < 16; i++) begin
      tick(1'b0, 1'b0, 16'h0, 1'b1, 4'(i), entryVal(i));
      chk("R9", {31'h0, cpuBusy}, 32'h0);
    end
    blank(8);
    for (int i = 0; i < 16; i++) model[i] = entryVal(i);
    curReq = "R3";
    showWord(16'h0123); showWord(16'h4567); showWord(16'h89AB); showWord(16'hCDEF);
    blank(4);

    // R2: nibble ordering sweep, every value in every position
    curReq = "R2";
    for (int k = 0; k < 16; k++)
      showWord({4'(k), 4'(k ^ 15), 4'((k + 5) & 15), 4'((k * 3) & 15)});
    blank(6);

    // R6/R7: fill the queue during an active line, then try a fifth write
    curReq = "R6";
    tick(1'b1, 1'b1, 16'h1235, 1'b1, 4'h1, 16'h0F0F);
    tick(1'b1, 1'b0, 16'h1235, 1'b1, 4'h2, 16'h3C3C);
    tick(1'b1, 1'b0, 16'h1235, 1'b1, 4'h3, 16'h1248);
    tick(1'b1, 1'b0, 16'h1235, 1'b1, 4'h1, 16'h7E81);
    chk("R7", {31'h0, cpuBusy}, 32'h1);
    tick(1'b1, 1'b1, 16'h1235, 1'b1, 4'h5, 16'hDEAD);
    chk("R7", {31'h0, cpuBusy}, 32'h1);
    for (int i = 0; i < 11; i++) tick(1'b1, (i % 4) == 3, 16'h1235, 1'b0, 4'h0, 16'h0);
    // R8: draining starts on the second blank clock
    tick(1'b0, 1'b0, 16'h0, 1'b0, 4'h0, 16'h0);
    chk("R8", {31'h0, cpuBusy}, 32'h1);
    tick(1'b0, 1'b0, 16'h0, 1'b0, 4'h0, 16'h0);
    chk("R8", {31'h0, cpuBusy}, 32'h0);
    blank(8);
    model[1] = 16'h7E81; model[2] = 16'h3C3C; model[3] = 16'h1248;
    curReq = "R8";
    showWord(16'h1235); showWord(16'h5321);
    curReq = "R7";
    showWord(16'h5555);
    blank(4);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule